// File: doc/BRIEF.md
# Random Replacement Index Generator

This block picks a pseudo-random entry number for a translation table that has to evict an entry. The table has a fixed number of entries, set by a parameter. The lowest entries can be pinned. The caller presents the current pinned count, `keep_cnt_i`, together with a one-cycle request pulse. Some cycles later the block answers with an index on `pick_idx_o` and a one-cycle `pick_vld_o` pulse. The index always lies between the pinned count and the last entry. It never repeats the index handed out by the previous request.

The random source is a 32-bit Galois shift register. To form a candidate, the register is stepped, its value is reduced modulo the number of unpinned entries, and the pinned count is added. When the candidate matches the previously returned index, the register steps again and a new candidate is formed. The modulo is computed by a restoring remainder unit that handles one dividend bit per cycle. A parameter can replace it with a single-cycle combinational reduction.

If one entry or none is left unpinned, the block answers at once with the last entry. It does not step the shift register in that case.

Top module: `rand_repl_idx`

## Requirements
- R1: After reset the shift register holds 1. With no pinned entries and 16 entries, the first request therefore returns index 1, because 0xD0000001 mod 16 is 1.
- R2: Each step shifts the 32-bit register right by one bit. If the bit shifted out was 1, the result is XORed with 0xD0000001. The register does not change between steps.
- R3: A candidate is (register value after the step) mod (entry count − pinned count), plus the pinned count.
- R4: If a candidate equals the previously returned index, the register steps again and a new candidate is formed. This repeats until the candidate differs. A returned index therefore never equals the one returned before it.
- R5: The previously returned index is 0 after reset. It is updated with every answer.
- R6: `pick_vld_o` is high for exactly one cycle per accepted request. `pick_idx_o` holds its value until the next answer.
- R7: When the pinned count is greater than or equal to the entry count minus one, the answer is the last entry. It arrives in the cycle after the request, and the shift register is not stepped.
- R8: A request that arrives while a computation is in progress is ignored. It produces no answer and does not disturb the computation in progress.
- R9: The pinned count is captured when the request is accepted. Changes on `keep_cnt_i` during the computation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle request pulse |
| keep_cnt_i | input | $clog2(NUM_ENTRIES+1) | Number of pinned low entries |
| pick_idx_o | output | $clog2(NUM_ENTRIES) | Chosen entry index |
| pick_vld_o | output | 1 | One-cycle pulse marking a new index |

## Verification
Assertions check the following on every cycle:
- every answer lies inside the unpinned range;
- an answer outside the fallback case never repeats the previous one;
- the valid pulse lasts one cycle;
- the shift register never reaches zero and holds between steps;
- each remainder stays below its divisor;
- the captured pinned count does not move while a request is being ignored.

Only the bench's scenarios can show three further properties. The exact index sequence follows the register polynomial and the modulo rule. The fallback path leaves the random sequence untouched. Ignored requests and late changes to the pinned count produce no extra answer and no change to the result.

// File: rtl/rand_repl_pkg.sv
package rand_repl_pkg;

   localparam int unsigned LFSR_W = 32;
   localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001;
   localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'hD000_0001;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_STEP  = 3'd1,
      ST_LOAD  = 3'd2,
      ST_DIV   = 3'd3,
      ST_CHECK = 3'd4
   } repl_state_t;

endpackage

// File: rtl/rand_repl_lfsr.sv
module rand_repl_lfsr #(
   parameter int unsigned WIDTH = 32,
   parameter logic [WIDTH-1:0] SEED = 1,
   parameter logic [WIDTH-1:0] TAPS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [WIDTH-1:0] val_o
);

   logic [WIDTH-1:0] val_q;
   logic [WIDTH-1:0] shifted;

   initial begin
      assert (WIDTH >= 2) else $error("lfsr width too small");
      assert (SEED != '0) else $error("lfsr seed must be nonzero");
   end

   always_comb begin
      shifted = val_q >> 1;
      if (val_q[0]) shifted = shifted ^ TAPS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      val_q <= SEED;
      else if (step_i) val_q <= shifted;
   end

   assign val_o = val_q;

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      val_q != '0); // R1

   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(val_q)); // R2

endmodule

// File: rtl/rand_repl_mod.sv
module rand_repl_mod #(
   parameter int unsigned DVD_W  = 32,
   parameter int unsigned DIV_W  = 5,
   parameter bit          SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DIV_W-1:0] divisor_i,
   output logic             done_o,
   output logic [DIV_W-1:0] rem_o
);

   localparam int unsigned CNT_W = $clog2(DVD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DVD_W - 1);

   logic [DIV_W-1:0] divisor_q;
   logic [DIV_W-1:0] rem_q;
   logic             done_q;

   initial begin
      assert (DVD_W >= 2) else $error("dividend too narrow");
      assert (DIV_W >= 2) else $error("divisor too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       divisor_q <= '0;
      else if (start_i) divisor_q <= divisor_i;
   end

   generate
      if (SERIAL) begin : g_serial
         logic [DVD_W-1:0] dvd_q;
         logic [CNT_W-1:0] bit_q;
         logic             run_q;
         logic [DIV_W:0]   trial;
         logic [DIV_W:0]   diff;

         always_comb begin
            trial = {rem_q, dvd_q[DVD_W-1]};
            diff  = trial - {1'b0, divisor_q};
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dvd_q  <= '0;
               bit_q  <= '0;
               run_q  <= 1'b0;
               rem_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b0;
               if (start_i) begin
                  dvd_q <= dividend_i;
                  bit_q <= '0;
                  rem_q <= '0;
                  run_q <= 1'b1;
               end else if (run_q) begin
                  dvd_q <= dvd_q << 1;
                  if (trial >= {1'b0, divisor_q}) rem_q <= diff[DIV_W-1:0];
                  else                            rem_q <= trial[DIV_W-1:0];
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == LAST_BIT) begin
                     run_q  <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rem_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= start_i;
               if (start_i) rem_q <= DIV_W'(dividend_i % DVD_W'(divisor_i));
            end
         end
      end
   endgenerate

   assign done_o = done_q;
   assign rem_o  = rem_q;

   AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> rem_q < divisor_q); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6

endmodule

// File: rtl/rand_repl_idx.sv
module rand_repl_idx #(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter bit          SERIAL_MOD  = 1'b1,
   parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES),
   parameter int unsigned CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [CNT_W-1:0] keep_cnt_i,
   output logic [IDX_W-1:0] pick_idx_o,
   output logic             pick_vld_o
);
   import rand_repl_pkg::*;

   localparam logic [CNT_W-1:0] LAST_ENT = CNT_W'(NUM_ENTRIES - 1);
   localparam logic [CNT_W-1:0] ENT_CNT  = CNT_W'(NUM_ENTRIES);

   initial begin
      assert (NUM_ENTRIES >= 2) else $error("need at least two entries");
      assert (IDX_W == $clog2(NUM_ENTRIES)) else $error("IDX_W mismatch");
      assert (CNT_W == $clog2(NUM_ENTRIES + 1)) else $error("CNT_W mismatch");
   end

   repl_state_t      state_q;
   logic [CNT_W-1:0] keep_q;
   logic [IDX_W-1:0] prev_q;
   logic [IDX_W-1:0] idx_q;
   logic             vld_q;

   logic             lfsr_step;
   logic [LFSR_W-1:0] lfsr_val;
   logic             mod_start;
   logic             mod_done;
   logic [CNT_W-1:0] mod_rem;
   logic [CNT_W-1:0] span;
   logic [CNT_W:0]   cand;

   assign span      = ENT_CNT - keep_q;
   assign cand      = {1'b0, mod_rem} + {1'b0, keep_q};
   assign lfsr_step = (state_q == ST_STEP);
   assign mod_start = (state_q == ST_LOAD);

   rand_repl_lfsr #(
      .WIDTH (LFSR_W),
      .SEED  (LFSR_SEED),
      .TAPS  (LFSR_TAPS)
   ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (lfsr_step),
      .val_o  (lfsr_val)
   );

   rand_repl_mod #(
      .DVD_W  (LFSR_W),
      .DIV_W  (CNT_W),
      .SERIAL (SERIAL_MOD)
   ) u_mod (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (mod_start),
      .dividend_i (lfsr_val),
      .divisor_i  (span),
      .done_o     (mod_done),
      .rem_o      (mod_rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         keep_q  <= '0;
         prev_q  <= '0;
         idx_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  keep_q <= keep_cnt_i;
                  if (keep_cnt_i >= LAST_ENT) begin
                     idx_q  <= IDX_W'(NUM_ENTRIES - 1);
                     prev_q <= IDX_W'(NUM_ENTRIES - 1);
                     vld_q  <= 1'b1;
                  end else begin
                     state_q <= ST_STEP;
                  end
               end
            end
            ST_STEP:  state_q <= ST_LOAD;
            ST_LOAD:  state_q <= ST_DIV;
            ST_DIV:   if (mod_done) state_q <= ST_CHECK;
            ST_CHECK: begin
               if (cand[IDX_W-1:0] == prev_q) begin
                  state_q <= ST_STEP;
               end else begin
                  idx_q   <= cand[IDX_W-1:0];
                  prev_q  <= cand[IDX_W-1:0];
                  vld_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign pick_idx_o = idx_q;
   assign pick_vld_o = vld_q;

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ({1'b0, idx_q} <= LAST_ENT) &&
               (({1'b0, idx_q} >= keep_q) || (keep_q >= LAST_ENT))); // R3

   AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && (keep_q < LAST_ENT) |-> idx_q != $past(prev_q)); // R4

   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q); // R6

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q |-> $stable(idx_q)); // R6

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) && req_i |=> $stable(keep_q)); // R8

   AST_FALLBACK_NOSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) && req_i && (keep_cnt_i >= LAST_ENT) |=> $stable(lfsr_val)); // R7

endmodule

// File: tb/rand_repl_idx_test.sv
module rand_repl_idx_test;

   localparam int unsigned N      = 16;
   localparam int unsigned IW     = $clog2(N);
   localparam int unsigned CW     = $clog2(N + 1);
   localparam time         CLK_HP = 5;
   localparam int          WAIT_LIMIT = 5000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [CW-1:0] keep_cnt_i = '0;
   logic [IW-1:0] pick_idx_o;
   logic          pick_vld_o;

   int total = 0;
   int bad   = 0;

   logic [31:0] m_lfsr;
   logic [IW-1:0] m_prev;

   always #CLK_HP clk = ~clk;

   rand_repl_idx #(.NUM_ENTRIES(N)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .keep_cnt_i (keep_cnt_i),
      .pick_idx_o (pick_idx_o),
      .pick_vld_o (pick_vld_o)
   );

   function automatic logic [31:0] lfsr_adv(input logic [31:0] v);
      logic [31:0] r;
      r = v >> 1;
      if (v[0]) r = r ^ 32'hD000_0001;
      return r;
   endfunction

   // Model of R2, R3, R4, R5, R7
   task automatic model_next(input int keep, output int exp_idx);
      int cand;
      if (keep >= N - 1) begin
         exp_idx = N - 1;
      end else begin
         do begin
            m_lfsr = lfsr_adv(m_lfsr);
            cand = int'(m_lfsr % (N - keep)) + keep;
         end while (cand == int'(m_prev));
         exp_idx = cand;
      end
      m_prev = IW'(exp_idx);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_vld(input string tag, output bit seen);
      seen = 0;
      for (int i = 0; i < WAIT_LIMIT; i++) begin
         if (pick_vld_o) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
      if (!seen) check({tag, " watchdog"}, 0, 1);
   endtask

   task automatic one_req(input int keep, input string tag);
      int exp;
      bit seen;
      @(negedge clk);
      keep_cnt_i = CW'(keep);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      model_next(keep, exp);
      wait_vld(tag, seen);
      if (seen) begin
         check(tag, int'(pick_idx_o), exp);
         @(negedge clk);
         check("R6 pulse width", int'(pick_vld_o), 0);
         check("R6 idx held", int'(pick_idx_o), exp);
      end
   endtask

   initial begin
      int exp;
      int vcount;
      bit seen;
      void'($urandom(32'd4242));
      m_lfsr = 32'h1;
      m_prev = '0;
      repeat (3) @(negedge clk);
      check("R6 reset valid", int'(pick_vld_o), 0);
      check("R5 reset idx", int'(pick_idx_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: seed 1 -> first step 0xD0000001, mod 16 = 1
      one_req(0, "R1 first pick");
      check("R1 first pick literal", int'(pick_idx_o), 1);

      // R7: fallback, no LFSR step; then next random result must follow model
      one_req(N - 1, "R7 fallback last");
      one_req(N, "R7 fallback full");
      one_req(3, "R3 after fallback");

      // R4: two-entry span forces alternation
      for (int k = 0; k < 6; k++) one_req(N - 2, "R4 span two");

      // R8 and R9: second request during computation, pinned count changes
      @(negedge clk);
      keep_cnt_i = CW'(5);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      model_next(5, exp);
      repeat (3) @(negedge clk);
      keep_cnt_i = CW'(N);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      keep_cnt_i = CW'(0);
      wait_vld("R9 latched count", seen);
      if (seen) check("R9 latched count", int'(pick_idx_o), exp);
      vcount = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (pick_vld_o) vcount++;
      end
      check("R8 ignored request no answer", vcount, 0);
      check("R8 idx unchanged", int'(pick_idx_o), exp);
      one_req(2, "R8 sequence undisturbed");

      // Random mix, R3 and R4
      for (int k = 0; k < 150; k++) begin
         int keep;
         keep = ($urandom % 8 == 0) ? int'($urandom % (N + 1)) : int'($urandom % (N - 1));
         one_req(keep, "R3 random pick");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule